// File: doc/BRIEF.md
# Quad DAC Dual-Rank Code Register Bank

This block keeps the digital state of four converter channels. Each channel has two register ranks. The first is a staging rank, written by serial commands that arrive already decoded as per-channel write strobes with a data word. The second is a presented rank, which feeds the converter. The width of a code is a parameter and may be 12, 10 or 8 bits.

A level-sensitive active-low load input controls the presented rank. While load is high, that rank is frozen. While load is low, it copies the staging rank on every clock. Three active-low preset inputs force both ranks to zero, midscale or full scale. A toggle mode lets one input choose which rank drives the outputs. A per-channel shutdown input blanks a channel's code and clears its active flag, and the load input has no effect on either.

Everything is synchronous to one clock. The reset is active-high and synchronous. The code and active-flag outputs are registered.

Top module: `dac_dual_rank_bank`

## Requirements
- R1: While `load_n` is high and no preset is low, the presented rank holds its value, and staging writes do not change `code_o` when toggle mode is off.
- R2: While `load_n` is low, each presented register takes its staging value on every clock edge, so `code_o` shows newly written staging data when toggle mode is off.
- R3: A channel whose `shdn` bit was 1 at the previous edge shows code 0 and has its `active_o` bit at 0. The state of `load_n` does not change this.
- R4: A write that commits while `load_n` is low reaches `code_o` on the second edge after the commit. As an input rule, `load_n` must then stay low for `HOLD_CYC` further cycles (30 cycles at 250 MHz, which is 120 ns).
- R5: With `set_n` low, and `mid_n` and `clr_n` high, both ranks of every channel become full scale, which is all ones.
- R6: With `mid_n` low and `clr_n` high, both ranks become midscale, which is the MSB set and all other bits 0. With `clr_n` low, both ranks become zero.
- R7: The presets rank in this order, highest first: clear, then mid, then set. Any active preset wins over a write strobe in the same cycle.
- R8: With `tog_en` high, `tog_sel` = 0 makes `code_o` show the staging rank and `tog_sel` = 1 makes it show the presented rank.
- R9: Reset sets both ranks, `code_o` and `active_o` to zero, with load treated as high.
- R10: With toggle mode selecting the staging rank, a write committed at edge k appears on `code_o` after edge k+1, and the old value is still shown after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NUM_CH | Per-channel staging write strobe |
| wr_data | input | NUM_CH*CODE_W | Per-channel write data, channel 0 in the low bits |
| load_n | input | 1 | Active-low level load of the presented rank |
| set_n | input | 1 | Active-low preset to full scale |
| mid_n | input | 1 | Active-low preset to midscale |
| clr_n | input | 1 | Active-low preset to zero |
| tog_en | input | 1 | Enables toggle rank selection |
| tog_sel | input | 1 | 0 shows the staging rank, 1 shows the presented rank |
| shdn | input | NUM_CH | Per-channel shutdown state |
| code_o | output | NUM_CH*CODE_W | Registered code per channel |
| active_o | output | NUM_CH | Registered per-channel active flag |

## Verification
The hold assertion assumes a rule about the inputs: once a write commits with `load_n` low, the driver keeps `load_n` low for `HOLD_CYC` cycles. The stimulus keeps to this rule in three ways. Each vector drops its write strobes after three cycles. It then keeps all its other inputs steady for `HOLD_CYC`+2 cycles before checking. Directed writes made under a low load are followed by a long low-load idle period. The assertions about preset and freeze outputs also assume the inputs were defined for the two edges before they look back, and a post-reset cycle counter keeps them from looking back into the reset period.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic [1:0] {
    PR_NONE = 2'd0,
    PR_FULL = 2'd1,
    PR_MID  = 2'd2,
    PR_ZERO = 2'd3
  } preset_e;
endpackage

// File: rtl/dacbank_preset_arb.sv
module dacbank_preset_arb #(
  parameter int CODE_W = 12
) (
  input  logic                 set_n,
  input  logic                 mid_n,
  input  logic                 clr_n,
  output dacbank_pkg::preset_e sel,
  output logic [CODE_W-1:0]    val
);
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};

  // clear outranks mid, mid outranks set
  always_comb begin
    if (!clr_n)      sel = dacbank_pkg::PR_ZERO;
    else if (!mid_n) sel = dacbank_pkg::PR_MID;
    else if (!set_n) sel = dacbank_pkg::PR_FULL;
    else             sel = dacbank_pkg::PR_NONE;
  end

  always_comb begin
    case (sel)
      dacbank_pkg::PR_FULL: val = FULL_CODE;
      dacbank_pkg::PR_MID:  val = MID_CODE;
      default:              val = '0;
    endcase
  end
endmodule

// File: rtl/dacbank_channel.sv
module dacbank_channel #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              load,
  input  logic              pre_act,
  input  logic [CODE_W-1:0] pre_val,
  input  logic              tog_en,
  input  logic              tog_sel,
  input  logic              shdn,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o
);
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] pres_q;
  logic [CODE_W-1:0] src;

  // toggle mode with sel low exposes the staging rank
  assign src = (tog_en && !tog_sel) ? stage_q : pres_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      pres_q   <= '0;
      code_o   <= '0;
      active_o <= 1'b0;
    end else begin
      if (pre_act) begin
        stage_q <= pre_val;
        pres_q  <= pre_val;
      end else begin
        if (wr_en) stage_q <= wr_data;
        if (load)  pres_q  <= stage_q;
      end
      active_o <= !shdn;
      code_o   <= shdn ? '0 : src;
    end
  end
endmodule

// File: rtl/dac_dual_rank_bank.sv
module dac_dual_rank_bank #(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 12,
  parameter int HOLD_CYC = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        wr_en,
  input  logic [NUM_CH*CODE_W-1:0] wr_data,
  input  logic                     load_n,
  input  logic                     set_n,
  input  logic                     mid_n,
  input  logic                     clr_n,
  input  logic                     tog_en,
  input  logic                     tog_sel,
  input  logic [NUM_CH-1:0]        shdn,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        active_o
);
  dacbank_pkg::preset_e pre_sel;
  logic [CODE_W-1:0]    pre_val;
  logic                 pre_act;
  logic                 load;

  assign pre_act = (pre_sel != dacbank_pkg::PR_NONE);
  assign load    = !load_n;

  dacbank_preset_arb #(.CODE_W(CODE_W)) arb_i (
    .set_n (set_n),
    .mid_n (mid_n),
    .clr_n (clr_n),
    .sel   (pre_sel),
    .val   (pre_val)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacbank_channel #(.CODE_W(CODE_W)) ch_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en[c]),
      .wr_data  (wr_data[c*CODE_W +: CODE_W]),
      .load     (load),
      .pre_act  (pre_act),
      .pre_val  (pre_val),
      .tog_en   (tog_en),
      .tog_sel  (tog_sel),
      .shdn     (shdn[c]),
      .code_o   (code_o[c*CODE_W +: CODE_W]),
      .active_o (active_o[c])
    );
  end
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 12,
  parameter int HOLD_CYC = 30
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        wr_en,
  input logic                     load_n,
  input logic                     set_n,
  input logic                     mid_n,
  input logic                     clr_n,
  input logic                     tog_en,
  input logic [NUM_CH-1:0]        shdn,
  input logic [NUM_CH*CODE_W-1:0] code_o,
  input logic [NUM_CH-1:0]        active_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [NUM_CH*CODE_W-1:0] ALL_FULL = {(NUM_CH*CODE_W){1'b1}};
  localparam logic [NUM_CH*CODE_W-1:0] ALL_MID  = {NUM_CH{MID_CODE}};

  logic [1:0]        cyc;
  logic [HW-1:0]     hold_cnt;
  logic [NUM_CH-1:0] shdn_d;
  logic              shdn_zero_ok;
  logic              no_pre;

  assign no_pre = set_n && mid_n && clr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      hold_cnt <= '0;
      shdn_d   <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      shdn_d <= shdn;
      if ((|wr_en) && !load_n && no_pre) hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0)           hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_comb begin
    shdn_zero_ok = 1'b1;
    for (int i = 0; i < NUM_CH; i++)
      if (shdn_d[i] && (code_o[i*CODE_W +: CODE_W] != '0)) shdn_zero_ok = 1'b0;
  end

  AST_FREEZE_WHILE_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(load_n, 2) && $past(no_pre, 2) && !$past(tog_en, 1) &&
     !$past(tog_en, 2) && ($past(shdn, 1) == $past(shdn, 2))) |-> $stable(code_o)); // R1

  AST_SHDN_BLANKS: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |-> (active_o == ~shdn_d) && shdn_zero_ok); // R3

  AST_LOAD_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) |-> !load_n); // R4

  AST_PRESET_FULL: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(!set_n && mid_n && clr_n, 2) && ($past(shdn, 1) == '0))
    |-> code_o == ALL_FULL); // R5

  AST_PRESET_MID: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(!mid_n && clr_n, 2) && ($past(shdn, 1) == '0))
    |-> code_o == ALL_MID); // R6

  AST_PRESET_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(!clr_n, 2)) |-> code_o == '0); // R7
endmodule

bind dac_dual_rank_bank dacbank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .load_n(load_n), .set_n(set_n),
  .mid_n(mid_n), .clr_n(clr_n), .tog_en(tog_en), .shdn(shdn),
  .code_o(code_o), .active_o(active_o)
);

// File: tb/dac_dual_rank_bank_tb_top.sv
`timescale 1ns/1ps
module dac_dual_rank_bank_tb_top;
  localparam int NCH  = 4;
  localparam int CW   = 12;
  localparam int HOLD = 30;

  typedef struct packed {
    logic [3:0]  wr;
    logic [11:0] base;
    logic        ld_n;
    logic        st_n;
    logic        md_n;
    logic        cl_n;
    logic        tg_en;
    logic        tg_sel;
    logic [3:0]  sd;
    logic [47:0] exp_code;
    logic [3:0]  exp_act;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 12'h100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'h000000000000, 4'hF, 4'd1},  // R1 write, load high
    '{4'h0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 48'h103102101100, 4'hF, 4'd8},  // R8 staging rank
    '{4'h0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 48'h000000000000, 4'hF, 4'd8},  // R8 presented rank
    '{4'h0, 12'h000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'h103102101100, 4'hF, 4'd2},  // R2 load low
    '{4'h5, 12'h200, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'h103202101200, 4'hF, 4'd2},  // R2 partial write
    '{4'hF, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'h103202101200, 4'hF, 4'd1},  // R1 frozen
    '{4'hF, 12'h010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'hFFFFFFFFFFFF, 4'hF, 4'd7},  // R7 preset beats write
    '{4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 48'h800800800800, 4'hF, 4'd7},  // R7 mid over set
    '{4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 48'h000000000000, 4'hF, 4'd7},  // R7 clear over all
    '{4'h0, 12'h000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 48'hFFFFFFFFFFFF, 4'hF, 4'd5},  // R5 full scale
    '{4'h0, 12'h000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 48'h800800800800, 4'hF, 4'd6},  // R6 midscale
    '{4'h0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 48'h000000000000, 4'hF, 4'd6},  // R6 zero
    '{4'hF, 12'h300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hA, 48'h000302000300, 4'h5, 4'd3},  // R3 shutdown, load low
    '{4'h0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 48'h303302301300, 4'hF, 4'd3}   // R3 wake
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  wr_en = '0;
  logic [NCH*CW-1:0] wr_data = '0;
  logic            load_n = 1'b1, set_n = 1'b1, mid_n = 1'b1, clr_n = 1'b1;
  logic            tog_en = 1'b0, tog_sel = 1'b0;
  logic [NCH-1:0]  shdn = '0;
  logic [NCH*CW-1:0] code_o;
  logic [NCH-1:0]  active_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dac_dual_rank_bank #(.NUM_CH(NCH), .CODE_W(CW), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .load_n(load_n),
    .set_n(set_n), .mid_n(mid_n), .clr_n(clr_n), .tog_en(tog_en),
    .tog_sel(tog_sel), .shdn(shdn), .code_o(code_o), .active_o(active_o)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check(code_o == '0, "R9 code", code_o, 48'h0);
    check(active_o == '0, "R9 active", {44'h0, active_o}, 48'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr_en   = VECS[v].wr;
      wr_data = {VECS[v].base + 12'd3, VECS[v].base + 12'd2, VECS[v].base + 12'd1, VECS[v].base};
      load_n  = VECS[v].ld_n;
      set_n   = VECS[v].st_n;
      mid_n   = VECS[v].md_n;
      clr_n   = VECS[v].cl_n;
      tog_en  = VECS[v].tg_en;
      tog_sel = VECS[v].tg_sel;
      shdn    = VECS[v].sd;
      repeat (3) @(negedge clk);
      wr_en = '0;
      repeat (HOLD + 2) @(negedge clk);
      check(code_o == VECS[v].exp_code, $sformatf("R%0d vec%0d code", VECS[v].rq, v),
            code_o, VECS[v].exp_code);
      check(active_o == VECS[v].exp_act, $sformatf("R%0d vec%0d active", VECS[v].rq, v),
            {44'h0, active_o}, {44'h0, VECS[v].exp_act});
    end

    // R10: staging rank shown one edge after the write edge
    load_n = 1'b1; tog_en = 1'b1; tog_sel = 1'b0; shdn = '0;
    wr_en = 4'h1; wr_data = {12'h0, 12'h0, 12'h0, 12'h5A5};
    @(negedge clk);
    wr_en = '0;
    check(code_o[11:0] == 12'h300, "R10 before", {36'h0, code_o[11:0]}, 48'h300);
    @(negedge clk);
    check(code_o[11:0] == 12'h5A5, "R10 after", {36'h0, code_o[11:0]}, 48'h5A5);

    // R4: write under low load reaches output on the second edge
    tog_en = 1'b0; load_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_en = 4'h2; wr_data = {12'h0, 12'h0, 12'h777, 12'h0};
    @(negedge clk);
    wr_en = '0;
    check(code_o[23:12] == 12'h301, "R4 edge1", {36'h0, code_o[23:12]}, 48'h301);
    @(negedge clk);
    check(code_o[23:12] == 12'h301, "R4 edge2", {36'h0, code_o[23:12]}, 48'h301);
    @(negedge clk);
    check(code_o[23:12] == 12'h777, "R4 edge3", {36'h0, code_o[23:12]}, 48'h777);
    repeat (HOLD + 5) @(negedge clk);

    // R9: mid-run reset clears both ranks
    load_n = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    check(code_o == '0, "R9 reset code", code_o, 48'h0);
    rst = 1'b0; tog_en = 1'b1; tog_sel = 1'b0;
    repeat (2) @(negedge clk);
    check(code_o == '0, "R9 staging zero", code_o, 48'h0);
    tog_sel = 1'b1;
    repeat (2) @(negedge clk);
    check(code_o == '0, "R9 presented zero", code_o, 48'h0);
    check(active_o == 4'hF, "R9 active after", {44'h0, active_o}, 48'hF);

    finish_run();
  end
endmodule